// File: doc/BRIEF.md
# Dual-Channel Converter Serial Control Interface

This block is the digital front end of a two-channel 8-bit converter. A host drives a three-wire serial link: an active-low chip select, a serial clock and a data line. Each rising serial clock edge with chip select low shifts one bit in, most significant bit first. When chip select rises after at least twelve bits, the last twelve bits form a frame. The frame holds a 2-bit channel address, a 2-bit power-down code and an 8-bit data byte. The block commits it to the two channel data registers, the power-down levels and the output-enable flags. The data line is also echoed back on a serial output, delayed by twelve and a half serial clock periods.

The serial lines are treated as slow inputs of the system clock. Chip select, serial clock and data pass through a two-stage synchronizer. Serial clock edges are then found by comparing the synchronized level with its value one cycle earlier. Every decoded output is a registered level that would drive the analog section of the converter.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset both channel data registers, all power-down outputs, both output-enable flags and the serial output are 0. A clear output-enable flag means that channel's output is high impedance.
- R2: A committed frame with address 01 (frame bits 11:10, sent first) loads bits 7:0 into channel A data and sets channel A output enable. Channel B is left unchanged.
- R3: A committed frame with address 10 loads bits 7:0 into channel B data and sets channel B output enable. Channel A is left unchanged.
- R4: A committed frame with address 11 loads the same byte into both channels and sets both output enables.
- R5: A committed frame with address 00 changes no data, power-down or output-enable output.
- R6: Every committed frame with a non-zero address sets the power-down outputs from bits 9:8. Code 01 powers down channel A only. Code 10 powers down channel B only. Code 11 asserts only the whole-device power down. Code 00 clears all three.
- R7: In a frame longer than twelve bits, only the last twelve bits before chip select rises are decoded. In a 16-bit frame the first four bits have no effect.
- R8: A frame of fewer than twelve bits is discarded when chip select rises, and no output changes.
- R9: On the serial clock falling edge that follows the rising edge sampling bit k+12 of a frame, the serial output takes the value of bit k.
- R10: While chip select is high, serial clock and data activity change neither the serial output nor any register output.
- R11: Once set, an output-enable flag stays set through later writes of any kind until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Delayed echo of serial data in |
| ch_a_data_o | output | 8 | Channel A data register |
| ch_b_data_o | output | 8 | Channel B data register |
| ch_a_pd_o | output | 1 | Channel A power down |
| ch_b_pd_o | output | 1 | Channel B power down |
| dev_pd_o | output | 1 | Whole-device power down |
| ch_a_oe_o | output | 1 | Channel A output enable (0 = high impedance) |
| ch_b_oe_o | output | 1 | Channel B output enable (0 = high impedance) |

## Verification
The hardest point to reach is the echo alignment on the serial output. A bit returns only after twelve further rising edges, and the first twelve falling edges of a frame replay bits left over from the previous frame. The stimulus therefore sends a single 24-bit frame and logs the output at every falling edge. It compares positions 12 to 23 against the first half of that frame. The last twelve bits of this frame carry a no-operation address, so the long frame leaves the registers untouched while the echo is checked.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;
  localparam int ADDR_W  = 2;
  localparam int PD_W    = 2;
  localparam int DATA_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int FRAME_W = ADDR_W + PD_W + DATA_W;

  // MSB-first: address, power-down code, data
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [PD_W-1:0]   pd;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam logic [PD_W-1:0] PD_ALL = '1;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_ni,
  input  logic   sclk_i,
  input  logic   sdi_i,
  output frame_t frame_o,
  output logic   commit_o,
  output logic   cs_sync_o,
  output logic   sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic       cs_s, sclk_s, sdi_s;
  logic       cs_q, sclk_q;
  logic       rise, fall, cs_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W:0]   shreg_q;  // one extra bit feeds the echo
  logic               sdo_q;

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign rise    =  sclk_s & ~sclk_q & ~cs_s;
  assign fall    = ~sclk_s &  sclk_q & ~cs_s;
  assign cs_rise =  cs_s   & ~cs_q;

  // saturating bit count; cleared while deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (cs_s)                              cnt_q <= '0;
    else if (rise && cnt_q != CNT_W'(FRAME_W))  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shreg_q <= '0;
    else if (rise) shreg_q <= {shreg_q[FRAME_W-1:0], sdi_s};
  end

  // bit sampled FRAME_W rises ago leaves on the next fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sdo_q <= 1'b0;
    else if (fall) sdo_q <= shreg_q[FRAME_W];
  end

  assign frame_o   = frame_t'(shreg_q[FRAME_W-1:0]);
  assign commit_o  = cs_rise && (cnt_q == CNT_W'(FRAME_W));
  assign cs_sync_o = cs_s;
  assign sdo_o     = sdo_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_serial_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  frame_t                         frame_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  data_o,
  output logic [NUM_CH-1:0]              pd_o,
  output logic [NUM_CH-1:0]              oe_o,
  output logic                           dev_pd_o
);
  logic active;
  assign active = commit_i && (frame_i.addr != '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic sel;
    assign sel = commit_i && frame_i.addr[ch];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[ch] <= '0;
        oe_o[ch]   <= 1'b0;
      end else if (sel) begin
        data_o[ch] <= frame_i.data;
        oe_o[ch]   <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pd_o[ch] <= 1'b0;
      else if (active) pd_o[ch] <= (frame_i.pd == PD_W'(1 << ch));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dev_pd_o <= 1'b0;
    else if (active) dev_pd_o <= (frame_i.pd == PD_ALL);
  end
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] ch_a_data_o,
  output logic [DATA_W-1:0] ch_b_data_o,
  output logic              ch_a_pd_o,
  output logic              ch_b_pd_o,
  output logic              dev_pd_o,
  output logic              ch_a_oe_o,
  output logic              ch_b_oe_o
);
  frame_t                        frame;
  logic                          commit;
  logic                          cs_sync;
  logic [NUM_CH-1:0][DATA_W-1:0] data;
  logic [NUM_CH-1:0]             pd;
  logic [NUM_CH-1:0]             oe;

  dac_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .frame_o   (frame),
    .commit_o  (commit),
    .cs_sync_o (cs_sync),
    .sdo_o     (sdo_o)
  );

  dac_reg_bank u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .frame_i  (frame),
    .data_o   (data),
    .pd_o     (pd),
    .oe_o     (oe),
    .dev_pd_o (dev_pd_o)
  );

  assign ch_a_data_o = data[0];
  assign ch_b_data_o = data[1];
  assign ch_a_pd_o   = pd[0];
  assign ch_b_pd_o   = pd[1];
  assign ch_a_oe_o   = oe[0];
  assign ch_b_oe_o   = oe[1];
endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk
  import dac_serial_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_sync,
  input logic              commit,
  input logic              sdo_o,
  input logic [DATA_W-1:0] ch_a_data_o,
  input logic [DATA_W-1:0] ch_b_data_o,
  input logic              ch_a_pd_o,
  input logic              ch_b_pd_o,
  input logic              dev_pd_o,
  input logic              ch_a_oe_o,
  input logic              ch_b_oe_o
);
  a_r6_pd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ch_a_pd_o, ch_b_pd_o, dev_pd_o}));

  a_r11_oe_a_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_a_oe_o |=> ch_a_oe_o);

  a_r11_oe_b_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_b_oe_o |=> ch_b_oe_o);

  a_r8_data_a_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ch_a_data_o));

  a_r8_data_b_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ch_b_data_o));

  a_r10_sdo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_sync |=> (cs_sync -> $stable(sdo_o)));

  a_r10_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable({ch_a_pd_o, ch_b_pd_o, dev_pd_o}));
endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_sync     (cs_sync),
  .commit      (commit),
  .sdo_o       (sdo_o),
  .ch_a_data_o (ch_a_data_o),
  .ch_b_data_o (ch_b_data_o),
  .ch_a_pd_o   (ch_a_pd_o),
  .ch_b_pd_o   (ch_b_pd_o),
  .dev_pd_o    (dev_pd_o),
  .ch_a_oe_o   (ch_a_oe_o),
  .ch_b_oe_o   (ch_b_oe_o)
);

// File: tb/dac_serial_ctrl_tb_top.sv
module dac_serial_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       sdo_o;
  logic [7:0] ch_a_data_o, ch_b_data_o;
  logic       ch_a_pd_o, ch_b_pd_o, dev_pd_o, ch_a_oe_o, ch_b_oe_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic sdo_log [32];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dac_serial_ctrl dut_i (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i, .sdo_o,
    .ch_a_data_o, .ch_b_data_o, .ch_a_pd_o, .ch_b_pd_o, .dev_pd_o,
    .ch_a_oe_o, .ch_b_oe_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // sends bits[n-1] first; logs sdo after every falling edge
  task automatic send_frame(input logic [31:0] bits, input int n);
    cs_ni = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < n; i++) begin
      sdi_i = bits[n-1-i];
      wait_n(HALF);
      sclk_i = 1'b1;
      wait_n(HALF);
      sclk_i = 1'b0;
      wait_n(HALF);
      sdo_log[i] = sdo_o;
    end
    cs_ni = 1'b1;
    wait_n(3*HALF);
  endtask

  task automatic chk_regs(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] pd, input logic [1:0] oe);
    chk({req, " data_a"}, ch_a_data_o, a);
    chk({req, " data_b"}, ch_b_data_o, b);
    chk({req, " pd"}, {ch_a_pd_o, ch_b_pd_o, dev_pd_o}, pd);
    chk({req, " oe"}, {ch_a_oe_o, ch_b_oe_o}, oe);
  endtask

  task automatic t_reset;
    chk_regs("R1", 8'h00, 8'h00, 3'b000, 2'b00);
    chk("R1 sdo", sdo_o, 1'b0);
  endtask

  task automatic t_write_a;
    send_frame({2'b01, 2'b00, 8'hA5}, 12);
    chk_regs("R2", 8'hA5, 8'h00, 3'b000, 2'b10);
  endtask

  task automatic t_write_b;
    send_frame({2'b10, 2'b00, 8'h3C}, 12);
    chk_regs("R3", 8'hA5, 8'h3C, 3'b000, 2'b11); // R11: oe_a stays
  endtask

  task automatic t_both;
    send_frame({2'b11, 2'b00, 8'h5A}, 12);
    chk_regs("R4", 8'h5A, 8'h5A, 3'b000, 2'b11);
  endtask

  task automatic t_nop;
    send_frame({2'b00, 2'b11, 8'hFF}, 12);
    chk_regs("R5", 8'h5A, 8'h5A, 3'b000, 2'b11);
  endtask

  task automatic t_pd;
    send_frame({2'b01, 2'b01, 8'h11}, 12);
    chk_regs("R6 code01", 8'h11, 8'h5A, 3'b100, 2'b11);
    send_frame({2'b10, 2'b10, 8'h22}, 12);
    chk_regs("R6 code10", 8'h11, 8'h22, 3'b010, 2'b11);
    send_frame({2'b01, 2'b11, 8'h33}, 12);
    chk_regs("R6 code11", 8'h33, 8'h22, 3'b001, 2'b11);
    send_frame({2'b00, 2'b00, 8'h44}, 12);
    chk_regs("R6 nop keeps pd", 8'h33, 8'h22, 3'b001, 2'b11);
    send_frame({2'b11, 2'b00, 8'h44}, 12);
    chk_regs("R6 code00", 8'h44, 8'h44, 3'b000, 2'b11);
  endtask

  task automatic t_long16;
    send_frame({4'b1101, 2'b10, 2'b00, 8'h77}, 16);
    chk_regs("R7", 8'h44, 8'h77, 3'b000, 2'b11);
  endtask

  task automatic t_short;
    send_frame({2'b11, 2'b11, 7'h55}, 11);
    chk_regs("R8", 8'h44, 8'h77, 3'b000, 2'b11);
  endtask

  task automatic t_sdo;
    logic [23:0] pat;
    pat = {12'hB39, 2'b00, 2'b01, 8'hC6};
    send_frame({8'h00, pat}, 24);
    for (int j = 12; j < 24; j++)
      chk("R9 sdo echo", sdo_log[j], pat[23-(j-12)]);
    chk_regs("R9 nop tail", 8'h44, 8'h77, 3'b000, 2'b11);
  endtask

  task automatic t_cs_high;
    logic held;
    held = sdo_o;
    for (int i = 0; i < 14; i++) begin
      sdi_i = ~held;
      wait_n(HALF);
      sclk_i = 1'b1;
      wait_n(HALF);
      sclk_i = 1'b0;
    end
    wait_n(3*HALF);
    chk("R10 sdo held", sdo_o, held);
    chk_regs("R10", 8'h44, 8'h77, 3'b000, 2'b11);
  endtask

  initial begin
    wait_n(4);
    rst_ni = 1'b1;
    wait_n(4);
    t_reset();
    t_write_a();
    t_write_b();
    t_both();
    t_nop();
    t_pd();
    t_long16();
    t_short();
    t_sdo();
    t_cs_high();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule